// File: doc/BRIEF.md
# GPIO Bank Pad Controller

This block controls one bank of general-purpose pins through a small 32-bit register bus. The bus has a word address, a write strobe, write data and combinational read data. Four registers hold the bank's settings. The mode register gives each pin a 4-bit mode nibble. The level register holds one output bit per pin. The pull register gives each pin a 2-bit pull selector. The drive register gives each pin a 2-bit drive-strength field in its lower half and a slew bit in its upper half.

From these registers the block drives the pad controls for every pin: output enable, output value, pull-up enable, pull-down enable, drive strength and slew. The block does not mux alternate functions. When a pin's nibble holds a code other than input or output, the block flags the pin as alternate and reports the nibble on a function-select output, so that an outside mux can act on it.

Reading the level register gives a live view of the bank. A pin in output mode returns its latched bit. Every other pin returns the pad input after a two-flop synchroniser. The reset input asserts asynchronously and is released through a two-stage synchroniser.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted, every register reads 0 and every pad control output is 0. This means all pins are inputs, with no pull, drive code 0 (1x) and slew clear.
- R2: The mode register (word address 0) holds pin i's nibble at bits 4i+3:4i. `pad_oe[i]` is 1 exactly when that nibble equals 1. Nibble 0 means input.
- R3: The level register (word address 1) holds pin i's bit at bit i, and `pad_out[i]` always follows that bit.
- R4: The pull register (word address 2) holds pin i's selector at bits 2i+1:2i. Code 1 sets `pad_pd[i]`, code 3 sets `pad_pu[i]`, and codes 0 and 2 set neither. The two pull outputs are never both 1 for the same pin.
- R5: The drive register (word address 3) holds pin i's strength at bits 2i+1:2i, which appears on `pad_drv[2i+1:2i]`. It holds pin i's slew bit at bit 16+i, which appears on `pad_slew[i]`.
- R6: Reading the level register returns the latched bit for a pin in output mode. For every other pin it returns `pad_in[i]` delayed by two clock edges.
- R7: A nibble of 2 or more sets `pin_alt[i]` and places the nibble on `pin_func[4i+3:4i]`. That field is 0 for input and output pins, and an alternate pin never has its output enable set.
- R8: Register bits that have no field are ignored on write and read as 0.
- R9: A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin output value |
| pad_pu | output | NUM_PINS | Per-pin pull-up enable |
| pad_pd | output | NUM_PINS | Per-pin pull-down enable |
| pad_drv | output | 2*NUM_PINS | Per-pin drive strength code |
| pad_slew | output | NUM_PINS | Per-pin slew control |
| pin_alt | output | NUM_PINS | Pin is in an alternate-function mode |
| pin_func | output | 4*NUM_PINS | Function code for alternate pins, 0 otherwise |

## Verification
The bench builds the block with the default of eight pins. With eight pins the mode nibbles fill all 32 bits, and the slew bits occupy bits 23:16 next to unused bits 31:24. The bench can therefore reach the top pin's nibble, the boundary between the drive and slew fields, and the masking of bits that have no field. It also times the synchroniser edge by edge, and it applies reset in the middle of a run to confirm that reset clears every register at once.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_LEVEL = 2'd1,
    REG_PULL  = 2'd2,
    REG_DRIVE = 2'd3
  } gpio_reg_e;

  localparam logic [3:0] MODE_INPUT  = 4'd0;
  localparam logic [3:0] MODE_OUTPUT = 4'd1;

  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd3;

  localparam int SLEW_BASE = 16;
  localparam int BUS_W     = 32;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  gpio_reg_e             wr_sel,
  input  logic [BUS_W-1:0]      wr_data,
  output logic [4*NUM_PINS-1:0] mode_q,
  output logic [NUM_PINS-1:0]   level_q,
  output logic [2*NUM_PINS-1:0] pull_q,
  output logic [2*NUM_PINS-1:0] drv_q,
  output logic [NUM_PINS-1:0]   slew_q
);
  localparam int MODE_W = 4 * NUM_PINS;
  localparam int PAIR_W = 2 * NUM_PINS;

  logic              mode_en, level_en, pull_en, drive_en;
  logic [MODE_W-1:0] mode_d;
  logic [NUM_PINS-1:0] level_d, slew_d;
  logic [PAIR_W-1:0] pull_d, drv_d;
  logic [BUS_W-1:0]  unused_wr_data;

  assign unused_wr_data = wr_data;

  always_comb begin
    mode_en  = wr_en && (wr_sel == REG_MODE);
    level_en = wr_en && (wr_sel == REG_LEVEL);
    pull_en  = wr_en && (wr_sel == REG_PULL);
    drive_en = wr_en && (wr_sel == REG_DRIVE);
    mode_d   = wr_data[MODE_W-1:0];
    level_d  = wr_data[NUM_PINS-1:0];
    pull_d   = wr_data[PAIR_W-1:0];
    drv_d    = wr_data[PAIR_W-1:0];
    slew_d   = wr_data[SLEW_BASE +: NUM_PINS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      level_q <= '0;
      pull_q  <= '0;
      drv_q   <= '0;
      slew_q  <= '0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (level_en) level_q <= level_d;
      if (pull_en)  pull_q  <= pull_d;
      if (drive_en) begin
        drv_q  <= drv_d;
        slew_q <= slew_d;
      end
    end
  end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_bank_pkg::*;
(
  input  logic [3:0] mode,
  input  logic       level,
  input  logic [1:0] pull,
  input  logic       pad_sync,
  output logic       oe,
  output logic       out,
  output logic       pu,
  output logic       pd,
  output logic       alt,
  output logic [3:0] func,
  output logic       rd_bit
);
  logic is_out;

  always_comb begin
    is_out = (mode == MODE_OUTPUT);
    alt    = (mode != MODE_INPUT) && !is_out;
    oe     = is_out;
    out    = level;
    pu     = (pull == PULL_UP);
    pd     = (pull == PULL_DOWN);
    func   = alt ? mode : 4'd0;
    rd_bit = is_out ? level : pad_sync;
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_pu,
  output logic [NUM_PINS-1:0]   pad_pd,
  output logic [2*NUM_PINS-1:0] pad_drv,
  output logic [NUM_PINS-1:0]   pad_slew,
  output logic [NUM_PINS-1:0]   pin_alt,
  output logic [4*NUM_PINS-1:0] pin_func
);
  localparam int MODE_W = 4 * NUM_PINS;
  localparam int PAIR_W = 2 * NUM_PINS;

  logic                rst_sync_n;
  logic [MODE_W-1:0]   mode_q;
  logic [NUM_PINS-1:0] level_q, slew_q, in_sync, rd_level;
  logic [PAIR_W-1:0]   pull_q, drv_q;

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_in   (pad_in),
    .sync_out (in_sync)
  );

  gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bus_wr),
    .wr_sel  (gpio_reg_e'(bus_addr)),
    .wr_data (bus_wdata),
    .mode_q  (mode_q),
    .level_q (level_q),
    .pull_q  (pull_q),
    .drv_q   (drv_q),
    .slew_q  (slew_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_slice u_slice (
      .mode     (mode_q[4*p +: 4]),
      .level    (level_q[p]),
      .pull     (pull_q[2*p +: 2]),
      .pad_sync (in_sync[p]),
      .oe       (pad_oe[p]),
      .out      (pad_out[p]),
      .pu       (pad_pu[p]),
      .pd       (pad_pd[p]),
      .alt      (pin_alt[p]),
      .func     (pin_func[4*p +: 4]),
      .rd_bit   (rd_level[p])
    );
  end

  assign pad_drv  = drv_q;
  assign pad_slew = slew_q;

  always_comb begin
    bus_rdata = '0;
    case (gpio_reg_e'(bus_addr))
      REG_MODE:  bus_rdata[MODE_W-1:0]   = mode_q;
      REG_LEVEL: bus_rdata[NUM_PINS-1:0] = rd_level;
      REG_PULL:  bus_rdata[PAIR_W-1:0]   = pull_q;
      REG_DRIVE: begin
        bus_rdata[PAIR_W-1:0]              = drv_q;
        bus_rdata[SLEW_BASE +: NUM_PINS]   = slew_q;
      end
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_ok,
  input logic [1:0]          bus_addr,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_pu,
  input logic [NUM_PINS-1:0] pad_pd,
  input logic [NUM_PINS-1:0] pad_slew,
  input logic [NUM_PINS-1:0] pin_alt
);
  p_pull_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (pad_pu & pad_pd) == '0);

  p_alt_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (pad_oe & pin_alt) == '0);

  p_mode_out_enables_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[3:0] == 4'd1) |=> pad_oe[0]);

  p_level_drives_out_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && bus_addr == 2'd1) |=> (pad_out == $past(bus_wdata[NUM_PINS-1:0])));

  p_slew_field_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && bus_addr == 2'd3) |=> (pad_slew == $past(bus_wdata[16 +: NUM_PINS])));

  p_other_write_keeps_slew_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && bus_addr != 2'd3) |=> $stable(pad_slew));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .pad_slew  (pad_slew),
  .pin_alt   (pin_alt)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    bus_addr;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in, pad_oe, pad_out, pad_pu, pad_pd, pad_slew, pin_alt;
  logic [2*NP-1:0] pad_drv;
  logic [4*NP-1:0] pin_func;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_drv(pad_drv), .pad_slew(pad_slew), .pin_alt(pin_alt), .pin_func(pin_func)
  );

  // {addr, write data, expected read-back}
  localparam logic [65:0] VEC [7] = '{
    {2'd2, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R8 pull upper bits dropped
    {2'd3, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R8 drive bits 31:24 dropped
    {2'd3, 32'h1234_5678, 32'h0034_5678},  // R5 drive and slew halves
    {2'd0, 32'h1111_1111, 32'h1111_1111},  // R2 every pin output
    {2'd1, 32'hFFFF_FF5A, 32'h0000_005A},  // R6 output pins latched, R8
    {2'd0, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R2 top nibble reached
    {2'd2, 32'h0000_C3E1, 32'h0000_C3E1}   // R4 pull codes
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b1; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = '0; pad_in = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 state during reset
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 reg reset", r, 32'h0);
    end
    chk("R1 pads", {pad_oe, pad_pu, pad_pd, pad_slew}, 32'h0);
    chk("R1 drive", {16'h0, pad_drv}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][65:64], VEC[i][63:32]);
      rd(VEC[i][65:64], r);
      chk($sformatf("R8 vector %0d read-back", i), r, VEC[i][31:0]);
    end

    // R9 later writes left drive alone
    rd(2'd3, r);
    chk("R9 drive kept", r, 32'h0034_5678);
    // R4 from 0xC3E1: pin0 code1, pin3/4/7 code3, pin2 code2
    chk("R4 pull-down", {24'h0, pad_pd}, 32'h01);
    chk("R4 pull-up", {24'h0, pad_pu}, 32'h98);
    // R7 all nibbles 5 or A
    chk("R7 alt", {24'h0, pin_alt}, 32'hFF);
    chk("R7 func", pin_func, 32'hA5A5_A5A5);
    chk("R7 no oe", {24'h0, pad_oe}, 32'h0);

    // R2/R3 pins 0,1 output, pin 2 alt code 2
    wr(2'd0, 32'h0000_0211);
    wr(2'd1, 32'h0000_0003);
    chk("R2 oe", {24'h0, pad_oe}, 32'h03);
    chk("R3 out", {24'h0, pad_out}, 32'h03);
    chk("R7 func mixed", pin_func, 32'h0000_0200);
    // R6 synchroniser latency
    @(negedge clk); pad_in = 8'hF0;
    @(negedge clk);
    rd(2'd1, r);
    chk("R6 one edge", r, 32'h03);
    @(negedge clk);
    rd(2'd1, r);
    chk("R6 two edges", r, 32'hF3);

    // R5 drive and slew outputs
    wr(2'd3, 32'h00A5_E41B);
    chk("R5 drive", {16'h0, pad_drv}, 32'hE41B);
    chk("R5 slew", {24'h0, pad_slew}, 32'hA5);

    // R3/R6 level written on input pins: driven value kept, read shows pad
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFF);
    pad_in = 8'h0F;
    repeat (3) @(negedge clk);
    chk("R3 out on inputs", {24'h0, pad_out}, 32'hFF);
    chk("R2 oe off", {24'h0, pad_oe}, 32'h0);
    rd(2'd1, r);
    chk("R6 input read", r, 32'h0F);

    // R1 reset in mid-run clears at once
    rst_n = 1'b0;
    #1;
    rd(2'd3, r);
    chk("R1 async drive", r, 32'h0);
    rd(2'd1, r);
    chk("R1 async level", r, 32'h0);
    chk("R1 async out", {24'h0, pad_out}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule